// File: doc/BRIEF.md
# Station-address PROM access decoder

This block sits between a host access port and the register side of a network controller. It holds a 16-byte station-address PROM and decides, for every host access, whether the access is served by the PROM, passed on to the controller's register port, or refused. The decision depends on four things: the window used (I/O or memory-mapped), the offset, the access size, and a configuration bit that puts the I/O window into 32-bit mode.

A refused read returns all ones across the access width. A refused write is dropped. A second configuration bit guards PROM writes. The register port is a plain request/acknowledge channel. The block holds a request on it until the far side acknowledges, and it does not accept a new host access while that request is open. Every accepted access completes with a one-cycle `rsp_valid` pulse.

Top module: `staprom_access_ctl`

## Requirements
- R1: After reset the PROM holds the parameter default address in bytes 0..5, with byte i taken from bits 8i+7:8i of the parameter, and zero in bytes 6..15. PROM write enable and 32-bit I/O mode are clear, `rsp_valid` and `rp_req` are low and `req_ready` is high.
- R2: With 32-bit I/O mode clear, I/O offsets below 0x10 serve byte accesses (size code 0) at any offset and 16-bit accesses (size code 1) at even offsets only. A 32-bit I/O access to the PROM is refused.
- R3: With 32-bit I/O mode set, I/O offsets below 0x10 serve only 32-bit accesses (size code 2) at offsets that are multiples of 4. Byte and 16-bit accesses there are refused.
- R4: A refused read returns ones across the access width: 0xFF for a byte, 0xFFFF for 16 bits, and 0xFFFFFFFF for 32 bits or the reserved size code 3. A refused write changes nothing.
- R5: A PROM write lands only while PROM write enable is set. Reads do not depend on that bit.
- R6: Multi-byte PROM data is little-endian: the byte at the lowest offset is bits 7:0, the next is bits 15:8, and so on.
- R7: In the memory window (`req_win`=1) with address bit 4 clear, every size from code 0 to 2 reaches the PROM at any alignment, whatever the I/O mode. Byte offsets wrap modulo 16.
- R8: In the memory window with address bit 4 set, 16-bit and 32-bit accesses go to the register port with the address reduced to its low 4 bits. Byte accesses there are refused: a read returns 0xFF, a write reaches neither the port nor the PROM.
- R9: In the I/O window at offsets 0x10 and above, 16-bit and 32-bit accesses go to the register port with the full offset, write flag, size and write data. Byte accesses there are refused.
- R10: Timing. A PROM or refused access raises `rsp_valid` in the cycle after acceptance. A port access raises `rp_req` in the cycle after acceptance and holds it, with its fields stable and `req_ready` low, until `rp_ack`. `rsp_valid` then follows one cycle later and carries `rp_rdata` on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Loads the two configuration bits below |
| cfg_prom_we | input | 1 | PROM write-enable value to load |
| cfg_wide | input | 1 | 32-bit I/O mode value to load |
| req_valid | input | 1 | Host access request |
| req_ready | output | 1 | Block can accept a request |
| req_win | input | 1 | 0 = I/O window, 1 = memory window |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 reserved |
| req_addr | input | AW | Offset within the window |
| req_wdata | input | 32 | Write data, little-endian lanes |
| rsp_valid | output | 1 | Access complete |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| rp_req | output | 1 | Register port request |
| rp_write | output | 1 | Register port write flag |
| rp_size | output | 2 | Register port size code |
| rp_addr | output | AW | Register port offset |
| rp_wdata | output | 32 | Register port write data |
| rp_ack | input | 1 | Register port acknowledge |
| rp_rdata | input | 32 | Register port read data |

## Verification
The bench builds the block with its default parameters: a 5-bit offset, a 16-byte PROM and a 6-byte default address. With those values the whole offset space of both windows is reachable, and a 32-bit memory-window read at offset 0xE crosses the wrap from byte 15 back to byte 0. It also reaches the split between PROM and register port at offset 0x10, and every size code under both I/O modes. Non-zero default address bytes make a lane-order mistake visible, and a port responder that waits before acknowledging exposes the hold of the request and its fields.

// File: rtl/staprom_pkg.sv
package staprom_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_PROM = 2'd1,
    RT_PORT = 2'd2
  } route_e;
endpackage

// File: rtl/staprom_decode.sv
module staprom_decode
  import staprom_pkg::*;
#(
  parameter int AW    = 5,
  parameter int IDX_W = 4
) (
  input  logic          win,
  input  logic [1:0]    size,
  input  logic [AW-1:0] addr,
  input  logic          wide,
  output route_e        route,
  output logic [2:0]    lanes,
  output logic [AW-1:0] fwd_addr
);
  acc_size_e sz;
  logic      multi;
  logic      io_low;

  assign sz     = acc_size_e'(size);
  assign multi  = (sz == SZ_HALF) || (sz == SZ_WORD);
  assign io_low = (addr >> IDX_W) == '0;

  always_comb begin
    route    = RT_NONE;
    fwd_addr = addr;
    unique case (sz)
      SZ_BYTE: lanes = 3'd1;
      SZ_HALF: lanes = 3'd2;
      default: lanes = 3'd4;
    endcase
    if (!win) begin
      if (io_low) begin
        if (!wide && sz == SZ_BYTE)                      route = RT_PROM;
        else if (!wide && sz == SZ_HALF && !addr[0])     route = RT_PROM;
        else if (wide && sz == SZ_WORD && addr[1:0] == 2'b00) route = RT_PROM;
      end else if (multi) begin
        route = RT_PORT;
      end
    end else begin
      if (!addr[IDX_W]) begin
        if (sz != SZ_RSVD) route = RT_PROM;
      end else if (multi) begin
        route    = RT_PORT;
        fwd_addr = AW'(addr[IDX_W-1:0]);
      end
    end
  end
endmodule

// File: rtl/staprom_store.sv
module staprom_store #(
  parameter int                    PROM_BYTES = 16,
  parameter int                    IDX_W      = 4,
  parameter int                    STA_BYTES  = 6,
  parameter logic [8*STA_BYTES-1:0] DEF_ADDR  = 48'hA5C3_8142_2002
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] base,
  input  logic [2:0]       lanes,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  localparam int NLANE = 4;

  typedef logic [PROM_BYTES-1:0][7:0] image_t;

  function automatic image_t reset_image();
    image_t img;
    logic [8*STA_BYTES-1:0] t;
    for (int i = 0; i < PROM_BYTES; i++) begin
      t = DEF_ADDR >> (8 * i);
      img[i] = (i < STA_BYTES) ? t[7:0] : 8'h00;
    end
    return img;
  endfunction

  localparam image_t RST_IMG = reset_image();

  image_t mem_q, mem_d;

  always_comb begin
    logic [IDX_W-1:0] off;
    logic [31:0]      sh;
    mem_d = mem_q;
    for (int i = 0; i < PROM_BYTES; i++) begin
      off = IDX_W'(i) - base;
      sh  = wdata >> {off[1:0], 3'b000};
      if (32'(off) < 32'(lanes)) mem_d[i] = sh[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mem_q <= RST_IMG;
    else if (wr_en) mem_q <= mem_d;
  end

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    assign rdata[8*k +: 8] = mem_q[base + IDX_W'(k)];
  end
endmodule

// File: rtl/staprom_access_ctl.sv
module staprom_access_ctl
  import staprom_pkg::*;
#(
  parameter int                    AW         = 5,
  parameter int                    PROM_BYTES = 16,
  parameter int                    STA_BYTES  = 6,
  parameter logic [8*STA_BYTES-1:0] DEF_ADDR  = 48'hA5C3_8142_2002
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_prom_we,
  input  logic          cfg_wide,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_win,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          rp_req,
  output logic          rp_write,
  output logic [1:0]    rp_size,
  output logic [AW-1:0] rp_addr,
  output logic [31:0]   rp_wdata,
  input  logic          rp_ack,
  input  logic [31:0]   rp_rdata
);
  localparam int IDX_W = $clog2(PROM_BYTES);

  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic          we_q, we_d, wide_q, wide_d;
  logic          rsp_valid_q, rsp_valid_d;
  logic [31:0]   rsp_rdata_q, rsp_rdata_d;
  logic          rp_req_q, rp_req_d;
  logic          rp_write_q;
  logic [1:0]    rp_size_q;
  logic [AW-1:0] rp_addr_q;
  logic [31:0]   rp_wdata_q;
  logic          accept, port_load, port_done, local_done;
  route_e        route;
  logic [2:0]    lanes;
  logic [AW-1:0] fwd_addr;
  logic [31:0]   prom_rd, width_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  staprom_decode #(.AW(AW), .IDX_W(IDX_W)) u_dec (
    .win(req_win), .size(req_size), .addr(req_addr), .wide(wide_q),
    .route(route), .lanes(lanes), .fwd_addr(fwd_addr)
  );

  staprom_store #(
    .PROM_BYTES(PROM_BYTES), .IDX_W(IDX_W),
    .STA_BYTES(STA_BYTES), .DEF_ADDR(DEF_ADDR)
  ) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(accept && req_write && route == RT_PROM && we_q),
    .base(req_addr[IDX_W-1:0]), .lanes(lanes), .wdata(req_wdata),
    .rdata(prom_rd)
  );

  assign req_ready  = !rp_req_q;
  assign accept     = req_valid && req_ready;
  assign port_load  = accept && route == RT_PORT;
  assign local_done = accept && route != RT_PORT;
  assign port_done  = rp_req_q && rp_ack;

  always_comb begin
    unique case (acc_size_e'(req_size))
      SZ_BYTE: width_mask = 32'h0000_00FF;
      SZ_HALF: width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  end

  always_comb begin
    we_d        = cfg_load ? cfg_prom_we : we_q;
    wide_d      = cfg_load ? cfg_wide    : wide_q;
    rsp_valid_d = local_done || port_done;
    rsp_rdata_d = rsp_rdata_q;
    if (local_done) begin
      if (req_write)              rsp_rdata_d = '0;
      else if (route == RT_PROM)  rsp_rdata_d = prom_rd & width_mask;
      else                        rsp_rdata_d = width_mask;
    end else if (port_done) begin
      rsp_rdata_d = rp_write_q ? '0 : rp_rdata;
    end
    rp_req_d = rp_req_q;
    if (port_load)      rp_req_d = 1'b1;
    else if (port_done) rp_req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      we_q        <= 1'b0;
      wide_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      rp_req_q    <= 1'b0;
      rp_write_q  <= 1'b0;
      rp_size_q   <= '0;
      rp_addr_q   <= '0;
      rp_wdata_q  <= '0;
    end else begin
      we_q        <= we_d;
      wide_q      <= wide_d;
      rsp_valid_q <= rsp_valid_d;
      rp_req_q    <= rp_req_d;
      if (local_done || port_done) rsp_rdata_q <= rsp_rdata_d;
      if (port_load) begin
        rp_write_q <= req_write;
        rp_size_q  <= req_size;
        rp_addr_q  <= fwd_addr;
        rp_wdata_q <= req_wdata;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
  assign rp_req    = rp_req_q;
  assign rp_write  = rp_write_q;
  assign rp_size   = rp_size_q;
  assign rp_addr   = rp_addr_q;
  assign rp_wdata  = rp_wdata_q;
endmodule

// File: rtl/staprom_access_chk.sv
module staprom_access_chk
  import staprom_pkg::*;
#(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_win,
  input logic [1:0]    req_size,
  input logic [AW-1:0] req_addr,
  input route_e        route,
  input logic          rp_req,
  input logic          rp_ack,
  input logic [AW-1:0] rp_addr,
  input logic          rp_write,
  input logic [31:0]   rp_wdata,
  input logic          rsp_valid
);
  // R10
  local_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && route != RT_PORT) |=> (rsp_valid && !rp_req));

  // R10
  port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_req && !rp_ack) |=> (rp_req && $stable(rp_addr) && $stable(rp_write)
                             && $stable(rp_wdata)));

  // R10
  port_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_req && rp_ack) |=> (rsp_valid && !rp_req));

  // R10
  port_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rp_req) |-> $past(req_valid && req_ready));

  // R10
  rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(rp_req && rp_ack)));

  // R8
  mem_byte_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_win && req_size == 2'd0 && req_addr[4])
      |=> !rp_req);

  // R10
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rp_req |-> !req_ready);
endmodule

bind staprom_access_ctl staprom_access_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_win(req_win), .req_size(req_size), .req_addr(req_addr), .route(route),
  .rp_req(rp_req), .rp_ack(rp_ack), .rp_addr(rp_addr), .rp_write(rp_write),
  .rp_wdata(rp_wdata), .rsp_valid(rsp_valid)
);

// File: tb/sim_staprom_access_ctl.sv
`timescale 1ns/1ps
module sim_staprom_access_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0, cfg_prom_we = 1'b0, cfg_wide = 1'b0;
  logic        req_valid = 1'b0, req_win = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rp_ack = 1'b0;
  logic [31:0] rp_rdata = '0;
  logic        req_ready, rsp_valid, rp_req, rp_write;
  logic [31:0] rsp_rdata, rp_wdata;
  logic [1:0]  rp_size;
  logic [4:0]  rp_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  staprom_access_ctl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_prom_we(cfg_prom_we),
    .cfg_wide(cfg_wide), .req_valid(req_valid), .req_ready(req_ready),
    .req_win(req_win), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rp_req(rp_req), .rp_write(rp_write),
    .rp_size(rp_size), .rp_addr(rp_addr), .rp_wdata(rp_wdata),
    .rp_ack(rp_ack), .rp_rdata(rp_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic cfg(input bit we, input bit wide);
    @(negedge clk);
    cfg_load = 1'b1; cfg_prom_we = we; cfg_wide = wide;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // One access; services the register port if the block raises a request.
  task automatic access(input bit win, input bit wr, input logic [1:0] sz,
                        input logic [4:0] a, input logic [31:0] wd,
                        input logic [31:0] port_val, output logic [31:0] rd,
                        output bit saw_port, output logic [4:0] pa,
                        output logic [1:0] psz, output bit pwr,
                        output logic [31:0] pwd);
    @(negedge clk);
    req_valid = 1'b1; req_win = win; req_write = wr; req_size = sz;
    req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    saw_port = rp_req;
    pa = rp_addr; psz = rp_size; pwr = rp_write; pwd = rp_wdata;
    if (rp_req) begin
      @(negedge clk);
      chk("R10 ready low while port busy", {31'b0, req_ready}, 32'd0);
      chk("R10 port addr held", {27'b0, rp_addr}, {27'b0, pa});
      chk("R10 no early response", {31'b0, rsp_valid}, 32'd0);
      rp_ack = 1'b1; rp_rdata = port_val;
      @(negedge clk);
      rp_ack = 1'b0;
      chk("R10 port request dropped", {31'b0, rp_req}, 32'd0);
    end
    chk("R10 response strobe", {31'b0, rsp_valid}, 32'd1);
    rd = rsp_rdata;
  endtask

  task automatic rd_local(input bit win, input logic [1:0] sz, input logic [4:0] a,
                          input string tag, input logic [31:0] exp);
    logic [31:0] rd, pwd; bit sp, pwr; logic [4:0] pa; logic [1:0] psz;
    access(win, 1'b0, sz, a, 32'h0, 32'h0, rd, sp, pa, psz, pwr, pwd);
    chk({tag, " no port"}, {31'b0, sp}, 32'd0);
    chk(tag, rd, exp);
  endtask

  task automatic wr_local(input bit win, input logic [1:0] sz, input logic [4:0] a,
                          input logic [31:0] wd, input string tag);
    logic [31:0] rd, pwd; bit sp, pwr; logic [4:0] pa; logic [1:0] psz;
    access(win, 1'b1, sz, a, wd, 32'h0, rd, sp, pa, psz, pwr, pwd);
    chk({tag, " no port"}, {31'b0, sp}, 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 rsp_valid low", {31'b0, rsp_valid}, 32'd0);
    chk("R1 rp_req low", {31'b0, rp_req}, 32'd0);
    chk("R1 ready high", {31'b0, req_ready}, 32'd1);
    rd_local(1'b1, 2'd2, 5'h00, "R1 bytes 0-3", 32'h8142_2002);
    rd_local(1'b1, 2'd2, 5'h04, "R1 bytes 4-7", 32'h0000_A5C3);
    rd_local(1'b1, 2'd2, 5'h08, "R1 bytes 8-11", 32'h0);
    rd_local(1'b1, 2'd2, 5'h0C, "R1 bytes 12-15", 32'h0);
  endtask

  task automatic t_io_narrow();
    rd_local(1'b0, 2'd0, 5'h03, "R2 byte odd offset", 32'h0000_0081);
    rd_local(1'b0, 2'd1, 5'h02, "R2 R6 half even", 32'h0000_8142);
    rd_local(1'b0, 2'd1, 5'h01, "R2 R4 half odd refused", 32'h0000_FFFF);
    rd_local(1'b0, 2'd2, 5'h00, "R2 R4 word refused", 32'hFFFF_FFFF);
    rd_local(1'b0, 2'd3, 5'h00, "R4 reserved size", 32'hFFFF_FFFF);
  endtask

  task automatic t_write_gate();
    wr_local(1'b0, 2'd0, 5'h06, 32'h55, "R5 gated write");
    rd_local(1'b0, 2'd0, 5'h06, "R5 write blocked", 32'h0);
    cfg(1'b1, 1'b0);
    wr_local(1'b0, 2'd0, 5'h06, 32'h55, "R5 enabled write");
    rd_local(1'b0, 2'd0, 5'h06, "R5 write landed", 32'h55);
    wr_local(1'b0, 2'd1, 5'h08, 32'hBEEF, "R6 half write");
    rd_local(1'b0, 2'd0, 5'h08, "R6 low lane first", 32'hEF);
    wr_local(1'b0, 2'd1, 5'h09, 32'h1234, "R4 odd half write");
    rd_local(1'b1, 2'd1, 5'h08, "R4 refused write no effect", 32'hBEEF);
  endtask

  task automatic t_io_wide();
    cfg(1'b1, 1'b1);
    rd_local(1'b0, 2'd2, 5'h04, "R3 R6 aligned word", 32'h0055_A5C3);
    rd_local(1'b0, 2'd2, 5'h02, "R3 misaligned word", 32'hFFFF_FFFF);
    rd_local(1'b0, 2'd0, 5'h00, "R3 byte refused", 32'h0000_00FF);
    rd_local(1'b0, 2'd1, 5'h00, "R3 half refused", 32'h0000_FFFF);
    wr_local(1'b0, 2'd2, 5'h0C, 32'hDDCC_BBAA, "R3 word write");
    rd_local(1'b1, 2'd0, 5'h0F, "R3 R6 top byte", 32'hDD);
    wr_local(1'b0, 2'd0, 5'h00, 32'h77, "R3 byte write refused");
    rd_local(1'b1, 2'd0, 5'h00, "R3 byte write no effect", 32'h02);
  endtask

  task automatic t_mem_wrap();
    rd_local(1'b1, 2'd2, 5'h0E, "R7 word wraps", 32'h2002_DDCC);
    wr_local(1'b1, 2'd1, 5'h0F, 32'h9911, "R7 half write wraps");
    rd_local(1'b1, 2'd2, 5'h0E, "R7 wrapped write", 32'h2099_11CC);
    rd_local(1'b1, 2'd3, 5'h00, "R4 mem reserved size", 32'hFFFF_FFFF);
  endtask

  task automatic t_port();
    logic [31:0] rd, pwd; bit sp, pwr; logic [4:0] pa; logic [1:0] psz;
    access(1'b0, 1'b0, 2'd1, 5'h12, 32'h0, 32'h0000_ABCD, rd, sp, pa, psz, pwr, pwd);
    chk("R9 half read forwarded", {31'b0, sp}, 32'd1);
    chk("R9 full offset", {27'b0, pa}, 32'h12);
    chk("R9 size", {30'b0, psz}, 32'd1);
    chk("R10 port read data", rd, 32'h0000_ABCD);
    access(1'b0, 1'b1, 2'd2, 5'h14, 32'hCAFE_F00D, 32'h0, rd, sp, pa, psz, pwr, pwd);
    chk("R9 word write forwarded", {31'b0, sp}, 32'd1);
    chk("R9 write flag", {31'b0, pwr}, 32'd1);
    chk("R9 write data", pwd, 32'hCAFE_F00D);
    rd_local(1'b0, 2'd0, 5'h10, "R9 byte refused", 32'h0000_00FF);
    access(1'b1, 1'b0, 2'd1, 5'h16, 32'h0, 32'h0000_1357, rd, sp, pa, psz, pwr, pwd);
    chk("R8 mem half forwarded", {31'b0, sp}, 32'd1);
    chk("R8 low 4 address bits", {27'b0, pa}, 32'h06);
    chk("R8 port read data", rd, 32'h0000_1357);
    rd_local(1'b1, 2'd0, 5'h13, "R8 mem byte read refused", 32'h0000_00FF);
    wr_local(1'b1, 2'd0, 5'h10, 32'h44, "R8 mem byte write dropped");
    rd_local(1'b1, 2'd0, 5'h00, "R8 PROM untouched", 32'h99);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_io_narrow();
    t_write_gate();
    t_io_wide();
    t_mem_wrap();
    t_port();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule